// File: doc/BRIEF.md
# Pulse-Interval Gap Write Decoder

This block turns a reader-to-tag command stream into bits. The reader sends data by briefly switching its field off. Each field-off period is a gap, and the length of the field-on stretch between two gaps carries one bit. The block runs on the field clock. It takes a synchronised gap level, measures run lengths, and classifies each symbol as a zero, a one or an error. A mode input selects either the normal timing windows or the shorter fast-write windows.

The first gap of a frame is the start gap. It is accepted only when the configuration-loaded input is high and its length lies in a fixed window. Each later gap closes a symbol. That symbol is classified from the field-on interval before the gap and from the gap's own length.

A frame ends when the field stays on too long after a gap. The block then pulses an end-of-frame strobe while the running bit count is valid, so a downstream command checker can validate the frame length. An error stays latched until the next start gap begins. While it is latched, all further bit strobes in that frame are suppressed.

The controller has five states:

- IDLE waits for a start gap.
- START_GAP measures the start gap.
- INTERVAL counts field-on clocks after a gap.
- DATA_GAP measures a data gap.
- ERROR waits out a failed frame.

The transitions are:

- IDLE to START_GAP: the gap is seen while configuration is loaded.
- START_GAP to INTERVAL: the start length is accepted.
- START_GAP to IDLE: the start length is rejected.
- INTERVAL to DATA_GAP: a gap is seen.
- INTERVAL to IDLE: timeout, which produces the end-of-frame strobe.
- DATA_GAP to INTERVAL: a valid symbol, which produces a bit strobe.
- DATA_GAP to ERROR: a bad symbol.
- ERROR to IDLE: timeout, with no strobe.

Top module: `gap_write_decoder`

## Requirements
- R1: After reset, bit_valid_o, bit_value_o, bit_count_o, err_o and frame_end_o are all 0, and the block waits for a start gap.
- R2: While cfg_ready_i is 0, gaps seen in the idle state are ignored: no bit, no error and no end-of-frame results.
- R3: A start gap (gap_i=1 run) of 10 to 50 clocks opens a frame and clears bit_count_o to 0. A start gap of any other length is dropped silently, with no error and no strobe.
- R4: In normal mode (fast_i=0), a field-on interval of 16 to 31 clocks before a gap gives bit 0, and one of 48 to 63 clocks gives bit 1. bit_valid_o pulses for one cycle, with bit_value_o, in the cycle after the clock that first samples the end of that gap.
- R5: In fast mode (fast_i=1), an interval of 8 to 15 clocks gives bit 0, and one of 24 to 31 clocks gives bit 1.
- R6: A data gap is valid for 8 to 30 clocks in normal mode and for 8 to 20 clocks in fast mode. Any other data gap length sets err_o.
- R7: An interval inside neither data window sets err_o in the cycle after the gap that ends it.
- R8: In the interval state, when field-on exceeds 64 clocks (normal) or 32 clocks (fast), frame_end_o pulses for one cycle in the cycle after the 65th (33rd) field-on sample. The block then returns to idle.
- R9: bit_count_o increments on each bit strobe and saturates at 127.
- R10: Once set, err_o stays 1 and suppresses bit strobes and the end-of-frame strobe. After a timeout the block returns to idle, and err_o clears when the next start gap begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Field clock |
| rst_ni | input | 1 | Active-low reset |
| cfg_ready_i | input | 1 | Configuration loaded; enables start gap acceptance |
| fast_i | input | 1 | 1 selects the fast-write timing windows |
| gap_i | input | 1 | Synchronised gap level, 1 while the field is off |
| bit_valid_o | output | 1 | One-cycle strobe for a decoded bit |
| bit_value_o | output | 1 | Decoded bit value, valid with bit_valid_o |
| bit_count_o | output | BCNT_W | Bits decoded in the current frame, saturating |
| err_o | output | 1 | Latched write error for the current frame |
| frame_end_o | output | 1 | One-cycle strobe when the gap stream times out |

## Verification
A run counter that is off by one shows up at the window edges within one symbol. In that case an interval of exactly 16, 31, 48 or 63 clocks (8, 15, 24 or 31 in fast mode) decodes as the wrong bit or as an error one cycle after the gap ends. A state machine stuck in the wrong state shows up as missing bit strobes, or as an end-of-frame strobe that fires one clock early or late relative to the 64- or 32-clock boundary. An error latch that clears too early lets strobes through for the symbols after a bad one. A count that wraps shows 0 rather than 127 at the end of a long frame.

// File: rtl/gapdec_pkg.sv
package gapdec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_GAP,
        ST_INTERVAL,
        ST_DATA_GAP,
        ST_ERROR
    } gd_state_e;

    typedef enum logic [1:0] {
        SYM_ZERO,
        SYM_ONE,
        SYM_BAD
    } gd_sym_e;

endpackage

// File: rtl/gapdec_run_timer.sv
module gapdec_run_timer #(
    parameter int W = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    output logic [W-1:0] run_o
);
    localparam logic [W-1:0] RUN_MAX = '1;

    // Counts samples of the current gap level; restart marks the first one.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            run_o <= '0;
        else if (restart_i)
            run_o <= W'(1);
        else if (run_o != RUN_MAX)
            run_o <= run_o + 1'b1;
    end

    // R8
    run_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart_i && run_o == RUN_MAX) |=> run_o == RUN_MAX);

endmodule

// File: rtl/gapdec_classify.sv
module gapdec_classify
    import gapdec_pkg::*;
#(
    parameter int W         = 7,
    parameter int GAP_MIN   = 8,
    parameter int GAP_MAX_N = 30,
    parameter int GAP_MAX_F = 20,
    parameter int N0_LO     = 16,
    parameter int N0_HI     = 31,
    parameter int N1_LO     = 48,
    parameter int N1_HI     = 63,
    parameter int F0_LO     = 8,
    parameter int F0_HI     = 15,
    parameter int F1_LO     = 24,
    parameter int F1_HI     = 31
) (
    input  logic         fast_i,
    input  logic [W-1:0] intv_i,
    input  logic [W-1:0] gap_len_i,
    output gd_sym_e      sym_o
);
    int iv;
    int gl;
    logic gap_ok;
    logic is_zero;
    logic is_one;

    assign iv = int'(intv_i);
    assign gl = int'(gap_len_i);

    always_comb begin
        if (fast_i) begin
            gap_ok  = (gl >= GAP_MIN) && (gl <= GAP_MAX_F);
            is_zero = (iv >= F0_LO) && (iv <= F0_HI);
            is_one  = (iv >= F1_LO) && (iv <= F1_HI);
        end else begin
            gap_ok  = (gl >= GAP_MIN) && (gl <= GAP_MAX_N);
            is_zero = (iv >= N0_LO) && (iv <= N0_HI);
            is_one  = (iv >= N1_LO) && (iv <= N1_HI);
        end
        if (!gap_ok)      sym_o = SYM_BAD;
        else if (is_zero) sym_o = SYM_ZERO;
        else if (is_one)  sym_o = SYM_ONE;
        else              sym_o = SYM_BAD;
    end

endmodule

// File: rtl/gap_write_decoder.sv
module gap_write_decoder
    import gapdec_pkg::*;
#(
    parameter int RUN_W     = 7,
    parameter int BCNT_W    = 7,
    parameter int START_MIN = 10,
    parameter int START_MAX = 50,
    parameter int GAP_MIN   = 8,
    parameter int GAP_MAX_N = 30,
    parameter int GAP_MAX_F = 20,
    parameter int N0_LO     = 16,
    parameter int N0_HI     = 31,
    parameter int N1_LO     = 48,
    parameter int N1_HI     = 63,
    parameter int F0_LO     = 8,
    parameter int F0_HI     = 15,
    parameter int F1_LO     = 24,
    parameter int F1_HI     = 31,
    parameter int TMO_N     = 64,
    parameter int TMO_F     = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_ready_i,
    input  logic              fast_i,
    input  logic              gap_i,
    output logic              bit_valid_o,
    output logic              bit_value_o,
    output logic [BCNT_W-1:0] bit_count_o,
    output logic              err_o,
    output logic              frame_end_o
);
    localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

    gd_state_e        state_q, state_d;
    logic             gap_q;
    logic             restart;
    logic [RUN_W-1:0] run_cnt;
    logic [RUN_W-1:0] intv_q;
    int               run_len;
    int               tmo;
    gd_sym_e          sym;

    logic start_begin, accept_start, latch_intv, take_bit, fault, timeout;

    assign run_len = int'(run_cnt);
    assign tmo     = fast_i ? TMO_F : TMO_N;
    assign restart = (state_q == ST_IDLE) || (gap_i != gap_q);

    gapdec_run_timer #(.W(RUN_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .run_o     (run_cnt)
    );

    gapdec_classify #(
        .W(RUN_W), .GAP_MIN(GAP_MIN), .GAP_MAX_N(GAP_MAX_N), .GAP_MAX_F(GAP_MAX_F),
        .N0_LO(N0_LO), .N0_HI(N0_HI), .N1_LO(N1_LO), .N1_HI(N1_HI),
        .F0_LO(F0_LO), .F0_HI(F0_HI), .F1_LO(F1_LO), .F1_HI(F1_HI)
    ) u_class (
        .fast_i    (fast_i),
        .intv_i    (intv_q),
        .gap_len_i (run_cnt),
        .sym_o     (sym)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            gap_q   <= 1'b0;
            intv_q  <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_i;
            if (latch_intv)
                intv_q <= run_cnt;
        end
    end

    // Next state and decisions
    always_comb begin
        state_d      = state_q;
        start_begin  = 1'b0;
        accept_start = 1'b0;
        latch_intv   = 1'b0;
        take_bit     = 1'b0;
        fault        = 1'b0;
        timeout      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_ready_i && gap_i) begin
                    state_d     = ST_START_GAP;
                    start_begin = 1'b1;
                end
            end
            ST_START_GAP: begin
                if (!gap_i) begin
                    if (run_len >= START_MIN && run_len <= START_MAX) begin
                        state_d      = ST_INTERVAL;
                        accept_start = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_INTERVAL: begin
                if (gap_i) begin
                    state_d    = ST_DATA_GAP;
                    latch_intv = 1'b1;
                end else if (run_len >= tmo) begin
                    state_d = ST_IDLE;
                    timeout = 1'b1;
                end
            end
            ST_DATA_GAP: begin
                if (!gap_i) begin
                    if (sym == SYM_BAD) begin
                        state_d = ST_ERROR;
                        fault   = 1'b1;
                    end else begin
                        state_d  = ST_INTERVAL;
                        take_bit = 1'b1;
                    end
                end
            end
            ST_ERROR: begin
                if (!gap_i && !gap_q && run_len >= tmo)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_valid_o <= 1'b0;
            bit_value_o <= 1'b0;
            frame_end_o <= 1'b0;
            err_o       <= 1'b0;
            bit_count_o <= '0;
        end else begin
            bit_valid_o <= take_bit;
            bit_value_o <= take_bit && (sym == SYM_ONE);
            frame_end_o <= timeout;
            if (start_begin)
                err_o <= 1'b0;
            else if (fault)
                err_o <= 1'b1;
            if (accept_start)
                bit_count_o <= '0;
            else if (take_bit && bit_count_o != BCNT_MAX)
                bit_count_o <= bit_count_o + 1'b1;
        end
    end

    // R10
    err_blocks_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !bit_valid_o);

    // R10
    frame_end_noerr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end_o |-> !err_o);

    // R8
    frame_end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end_o |=> !frame_end_o);

    // R2
    cfg_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !cfg_ready_i) |=> state_q == ST_IDLE);

    // R9
    count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_count_o == BCNT_MAX && state_q != ST_START_GAP) |=> bit_count_o == BCNT_MAX);

endmodule

// File: tb/gap_write_decoder_tb_top.sv
module gap_write_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_ready;
    logic       fast;
    logic       gap;
    logic       bit_valid_o;
    logic       bit_value_o;
    logic [6:0] bit_count_o;
    logic       err_o;
    logic       frame_end_o;

    always #5 clk = ~clk;

    gap_write_decoder dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_ready_i (cfg_ready),
        .fast_i      (fast),
        .gap_i       (gap),
        .bit_valid_o (bit_valid_o),
        .bit_value_o (bit_value_o),
        .bit_count_o (bit_count_o),
        .err_o       (err_o),
        .frame_end_o (frame_end_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int rx_n = 0;
    int fe_n = 0;
    int fe_cnt = 0;
    logic [255:0] rx_bits;

    // Monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (bit_valid_o) begin
            if (rx_n < 256) rx_bits[rx_n] = bit_value_o;
            rx_n = rx_n + 1;
        end
        if (frame_end_o) begin
            fe_n   = fe_n + 1;
            fe_cnt = int'(bit_count_o);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        rx_n = 0; fe_n = 0; fe_cnt = 0; rx_bits = '0;
    endtask

    task automatic gap_for(input int n);
        gap = 1'b1;
        repeat (n) @(negedge clk);
        gap = 1'b0;
    endtask

    task automatic field_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_sym(input int intv, input int glen);
        field_for(intv);
        gap_for(glen);
    endtask

    task automatic t_reset();
        check("R1 bit_valid", int'(bit_valid_o), 0);
        check("R1 bit_value", int'(bit_value_o), 0);
        check("R1 bit_count", int'(bit_count_o), 0);
        check("R1 err", int'(err_o), 0);
        check("R1 frame_end", int'(frame_end_o), 0);
    endtask

    task automatic t_cfg_gate();
        clear_log();
        cfg_ready = 1'b0;
        gap_for(20);
        send_sym(24, 10);
        field_for(70);
        check("R2 bits while unconfigured", rx_n, 0);
        check("R2 frame end while unconfigured", fe_n, 0);
        check("R2 err while unconfigured", int'(err_o), 0);
        cfg_ready = 1'b1;
    endtask

    task automatic t_normal();
        int exp_bits[6] = '{0, 1, 0, 0, 1, 1};
        clear_log();
        fast = 1'b0;
        gap_for(20);
        send_sym(24, 10);
        send_sym(54, 10);
        send_sym(16, 10);
        send_sym(31, 12);
        send_sym(48, 30);
        send_sym(63, 8);
        field_for(70);
        check("R4 bit count of strobes", rx_n, 6);
        for (int i = 0; i < 6; i++)
            check("R4 normal bit value", int'(rx_bits[i]), exp_bits[i]);
        check("R6 gaps 8 and 30 accepted", int'(err_o), 0);
        check("R8 one frame end", fe_n, 1);
        check("R9 count at frame end", fe_cnt, 6);
    endtask

    task automatic t_start_limits();
        clear_log();
        fast = 1'b0;
        gap_for(9);
        field_for(70);
        gap_for(51);
        field_for(70);
        check("R3 short/long start ignored bits", rx_n, 0);
        check("R3 short/long start ignored frame", fe_n, 0);
        check("R3 short/long start no err", int'(err_o), 0);
        for (int k = 0; k < 2; k++) begin
            clear_log();
            gap_for(k == 0 ? 10 : 50);
            send_sym(54, 10);
            field_for(70);
            check("R3 start limit accepted bits", rx_n, 1);
            check("R3 start limit bit value", int'(rx_bits[0]), 1);
            check("R3 start limit frame count", fe_cnt, 1);
        end
    endtask

    task automatic t_fast();
        int exp_bits[6] = '{0, 0, 1, 1, 0, 1};
        clear_log();
        fast = 1'b1;
        gap_for(15);
        send_sym(8, 8);
        send_sym(15, 20);
        send_sym(24, 8);
        send_sym(31, 10);
        send_sym(12, 8);
        send_sym(27, 8);
        field_for(32);
        check("R8 fast no timeout at 32", int'(frame_end_o), 0);
        field_for(1);
        check("R8 fast timeout at 33", int'(frame_end_o), 1);
        field_for(5);
        check("R5 fast strobes", rx_n, 6);
        for (int i = 0; i < 6; i++)
            check("R5 fast bit value", int'(rx_bits[i]), exp_bits[i]);
        check("R8 fast frame ends once", fe_n, 1);
        check("R9 fast count", fe_cnt, 6);
        fast = 1'b0;
    endtask

    task automatic t_normal_timeout();
        clear_log();
        fast = 1'b0;
        gap_for(20);
        send_sym(24, 10);
        field_for(64);
        check("R8 normal no timeout at 64", int'(frame_end_o), 0);
        field_for(1);
        check("R8 normal timeout at 65", int'(frame_end_o), 1);
        field_for(5);
        check("R8 normal frame count", fe_cnt, 1);
    endtask

    task automatic t_bad_interval();
        clear_log();
        fast = 1'b0;
        gap_for(20);
        send_sym(24, 10);
        send_sym(54, 10);
        send_sym(40, 10);
        field_for(1);
        check("R7 interval 40 sets err", int'(err_o), 1);
        send_sym(24, 10);
        send_sym(54, 10);
        field_for(70);
        check("R10 strobes suppressed after err", rx_n, 2);
        check("R10 no frame end after err", fe_n, 0);
        check("R10 err held", int'(err_o), 1);
        clear_log();
        gap_for(20);
        check("R10 err cleared by start gap", int'(err_o), 0);
        send_sym(54, 10);
        field_for(70);
        check("R10 decoding resumes", rx_n, 1);
        check("R10 frame end resumes", fe_n, 1);
    endtask

    task automatic t_bad_gap();
        clear_log();
        fast = 1'b0;
        gap_for(20);
        send_sym(24, 31);
        field_for(1);
        check("R6 normal gap 31 err", int'(err_o), 1);
        field_for(70);
        fast = 1'b1;
        gap_for(20);
        send_sym(8, 21);
        field_for(1);
        check("R6 fast gap 21 err", int'(err_o), 1);
        field_for(40);
        gap_for(20);
        send_sym(8, 7);
        field_for(1);
        check("R6 fast gap 7 err", int'(err_o), 1);
        field_for(40);
        check("R6 no strobes for bad gaps", rx_n, 0);
        fast = 1'b0;
    endtask

    task automatic t_saturate();
        clear_log();
        fast = 1'b1;
        gap_for(20);
        repeat (130) send_sym(8, 8);
        field_for(40);
        check("R9 strobes for long frame", rx_n, 130);
        check("R9 count saturates at 127", fe_cnt, 127);
        clear_log();
        gap_for(20);
        field_for(1);
        check("R9 count cleared by start", int'(bit_count_o), 0);
        field_for(40);
        fast = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        rst_n = 1'b0; cfg_ready = 1'b0; fast = 1'b0; gap = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        field_for(2);
        t_cfg_gate();
        t_normal();
        t_start_limits();
        t_fast();
        t_normal_timeout();
        t_bad_interval();
        t_bad_gap();
        t_saturate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule